// File: doc/BRIEF.md
# Tuple History Compressor

This block is the second compression stage for a stream of small cache-index codes. It groups successive index bytes into tuples of N bytes each. For every complete tuple, it looks for an identical tuple in a small history of recently seen tuples.

If the tuple is found, the block emits only the tuple's position in the history. If it is not found, the block emits position zero as a miss code together with the full tuple. The new tuple then replaces the oldest history entry in first-in-first-out order.

Upstream logic offers bytes under a valid/ready handshake. While a lookup is in progress, the block holds its ready output low. Downstream logic takes the position output and the raw-tuple output as single-cycle pulses.

Top module: `tuple_hist_comp`

## Requirements
- R1: After reset, in_ready is 1 and hit_valid and miss_valid are 0. The history is empty, so the first tuple always misses.
- R2: A byte is taken only in a cycle where in_valid and in_ready are both 1. The k-th byte taken (k counts from 0) occupies bits [8k+7:8k] of the tuple. From the cycle after the N-th byte is taken until the result cycle, in_ready is 0 and in_valid has no effect.
- R3: A miss produces one cycle with hit_valid=1, hit_pos=0 and miss_valid=1. In that cycle, miss_tuple carries the whole tuple.
- R4: A hit requires all N bytes to match a valid entry. It produces one cycle with hit_valid=1, miss_valid=0, and hit_pos equal to the matching position, which lies in 1..DEPTH.
- R5: A miss writes the tuple at the insertion position, which starts at 1 after reset. The insertion position then advances by one and wraps from DEPTH back to 1, so each later miss overwrites the oldest entry.
- R6: A hit changes neither the stored entries nor the insertion position.
- R7: The scan checks positions in ascending order, one per cycle, and stops at the first position that is either empty or matching. The result appears p cycles after the clock edge that took the last byte. Here p is that stopping position, or DEPTH if every position is valid and none matches.
- R8: in_ready returns to 1 in the result cycle, and a byte offered in that cycle is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Index byte offered |
| in_idx | input | IDX_W | Index byte |
| in_ready | output | 1 | Block can take a byte |
| hit_valid | output | 1 | Lookup result pulse |
| hit_pos | output | $clog2(DEPTH+1) | Matching position, or 0 for a miss |
| miss_valid | output | 1 | Raw tuple pulse, only on a miss |
| miss_tuple | output | N*IDX_W | Raw tuple, first byte in the low bits |

## Verification
Each result is due exactly p cycles after the edge that takes the last byte of a tuple. Here p is the scan stop position, computed by a reference model of the history contents and insertion position. The bench samples on falling edges. In each of the p-1 intervening cycles it checks that no result pulse is present and that ready is low, and it then checks the result in exactly the p-th cycle. The next tuple's first byte is offered in that same result cycle, so the ready-return timing is checked on every tuple.

// File: rtl/tht_pkg.sv
package tht_pkg;

    // Advance a 1-based insertion position, wrapping from depth back to 1.
    function automatic int unsigned tht_next_pos(input int unsigned pos, input int unsigned depth);
        return (pos >= depth) ? 1 : pos + 1;
    endfunction

endpackage

// File: rtl/tht_gather.sv
module tht_gather #(
    parameter int N     = 4,
    parameter int IDX_W = 8,
    localparam int TW   = N * IDX_W,
    localparam int CW   = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IDX_W-1:0] byte_in,
    input  logic          clear,
    output logic          full,
    output logic [TW-1:0] tuple
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [TW-1:0] data;
    } gather_t;

    gather_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (clear) begin
            g_d.cnt = '0;
        end else if (push) begin
            for (int i = 0; i < N; i++) begin
                if (g_q.cnt == CW'(i)) begin
                    g_d.data[i*IDX_W +: IDX_W] = byte_in;
                end
            end
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign full  = (g_q.cnt == CW'(N));
    assign tuple = g_q.data;

endmodule

// File: rtl/tht_table.sv
module tht_table #(
    parameter int TW    = 32,
    parameter int DEPTH = 255,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rd_pos,
    output logic          rd_valid,
    output logic [TW-1:0] rd_tuple,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_pos,
    input  logic [TW-1:0] wr_tuple
);

    logic [TW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] vld_d, vld_q;
    logic [PW-1:0]    rd_i, wr_i;

    // Positions are 1-based; position 0 is never stored.
    assign rd_i = rd_pos - 1'b1;
    assign wr_i = wr_pos - 1'b1;

    always_comb begin
        vld_d = vld_q;
        if (wr_en) begin
            vld_d[wr_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_i] <= wr_tuple;
        end
    end

    assign rd_valid = vld_q[rd_i];
    assign rd_tuple = mem[rd_i];

endmodule

// File: rtl/tuple_hist_comp.sv
module tuple_hist_comp #(
    parameter int N     = 4,
    parameter int IDX_W = 8,
    parameter int DEPTH = 255,
    localparam int TW   = N * IDX_W,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    output logic             in_ready,
    output logic             hit_valid,
    output logic [PW-1:0]    hit_pos,
    output logic             miss_valid,
    output logic [TW-1:0]    miss_tuple
);

    import tht_pkg::*;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] wr;
        logic          hit_v;
        logic [PW-1:0] hit_p;
        logic          miss_v;
        logic [TW-1:0] miss_t;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic          full;
    logic [TW-1:0] tuple;
    logic          clr;
    logic          rd_vld;
    logic [TW-1:0] rd_tup;
    logic          wr_en;

    tht_gather #(.N(N), .IDX_W(IDX_W)) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (in_valid && !full),
        .byte_in (in_idx),
        .clear   (clr),
        .full    (full),
        .tuple   (tuple)
    );

    tht_table #(.TW(TW), .DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pos   (c_q.ptr),
        .rd_valid (rd_vld),
        .rd_tuple (rd_tup),
        .wr_en    (wr_en),
        .wr_pos   (c_q.wr),
        .wr_tuple (tuple)
    );

    always_comb begin
        c_d        = c_q;
        c_d.hit_v  = 1'b0;
        c_d.miss_v = 1'b0;
        clr        = 1'b0;
        wr_en      = 1'b0;
        if (full) begin
            if (rd_vld && (rd_tup == tuple)) begin
                c_d.hit_v = 1'b1;
                c_d.hit_p = c_q.ptr;
                c_d.ptr   = PW'(1);
                clr       = 1'b1;
            end else if (!rd_vld || (c_q.ptr == PW'(DEPTH))) begin
                c_d.hit_v  = 1'b1;
                c_d.hit_p  = '0;
                c_d.miss_v = 1'b1;
                c_d.miss_t = tuple;
                c_d.wr     = PW'(tht_next_pos(int'(c_q.wr), DEPTH));
                c_d.ptr    = PW'(1);
                wr_en      = 1'b1;
                clr        = 1'b1;
            end else begin
                c_d.ptr = c_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.ptr <= PW'(1);
            c_q.wr  <= PW'(1);
        end else begin
            c_q <= c_d;
        end
    end

    assign in_ready   = !full;
    assign hit_valid  = c_q.hit_v;
    assign hit_pos    = c_q.hit_p;
    assign miss_valid = c_q.miss_v;
    assign miss_tuple = c_q.miss_t;

endmodule

// File: rtl/tht_checker.sv
module tht_checker #(
    parameter int DEPTH = 255,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          hit_valid,
    input logic [PW-1:0] hit_pos,
    input logic          miss_valid
);

    // R3: a raw tuple always comes with the zero position code
    p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (hit_valid && hit_pos == '0));

    // R4: a hit reports a position inside the table
    p_hit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !miss_valid) |-> (hit_pos != '0 && hit_pos <= PW'(DEPTH)));

    // R3: results are single-cycle pulses
    p_result_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> !hit_valid);

    // R2: ready drops only after a byte was taken
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid));

    // R8: ready comes back together with the result
    p_ready_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> hit_valid);

endmodule

bind tuple_hist_comp tht_checker #(.DEPTH(DEPTH)) u_tht_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .hit_valid  (hit_valid),
    .hit_pos    (hit_pos),
    .miss_valid (miss_valid)
);

// File: tb/tuple_hist_comp_test.sv
module tuple_hist_comp_test;

    localparam int N     = 4;
    localparam int IDX_W = 8;
    localparam int D     = 4;
    localparam int TW    = N * IDX_W;
    localparam int PW    = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_idx = '0;
    logic          in_ready;
    logic          hit_valid;
    logic [PW-1:0] hit_pos;
    logic          miss_valid;
    logic [TW-1:0] miss_tuple;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model, positions 1..D
    logic [TW-1:0] mtab [1:D];
    bit            mval [1:D];
    int            mwr;

    always #5 clk = ~clk;

    tuple_hist_comp #(.N(N), .IDX_W(IDX_W), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx),
        .in_ready(in_ready), .hit_valid(hit_valid), .hit_pos(hit_pos),
        .miss_valid(miss_valid), .miss_tuple(miss_tuple)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sends one tuple (low byte first) starting at the current falling edge.
    // exp_pos is the hand-derived expected position (0 = miss).
    task automatic run_tuple(input logic [TW-1:0] t, input int exp_pos, input bit junk, input string tag);
        int lat;
        bit hit;
        lat = D;
        hit = 1'b0;
        for (int p = 1; p <= D; p++) begin
            if (!mval[p]) begin lat = p; break; end
            if (mtab[p] == t) begin lat = p; hit = 1'b1; break; end
        end
        check(hit == (exp_pos != 0), {tag, " model agrees R4"}, 64'(hit), 64'(exp_pos != 0));
        for (int i = 0; i < N; i++) begin
            check(in_ready == 1'b1, {tag, " R2 ready before byte"}, 64'(in_ready), 64'd1);
            in_valid = 1'b1;
            in_idx   = t[i*8 +: 8];
            @(negedge clk);
        end
        in_valid = junk;
        in_idx   = 8'hEE;
        for (int k = 1; k < lat; k++) begin
            check(!hit_valid && !miss_valid, {tag, " R7 no early result"}, 64'(hit_valid), 64'd0);
            check(!in_ready, {tag, " R2 busy ready low"}, 64'(in_ready), 64'd0);
            @(negedge clk);
        end
        check(!hit_valid, {tag, " R7 no early result"}, 64'(hit_valid), 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check(hit_valid == 1'b1, {tag, " R7 result on time"}, 64'(hit_valid), 64'd1);
        check(hit_pos == PW'(exp_pos), {tag, " R4 position"}, 64'(hit_pos), 64'(exp_pos));
        check(miss_valid == (exp_pos == 0), {tag, " R3 miss flag"}, 64'(miss_valid), 64'(exp_pos == 0));
        if (exp_pos == 0) begin
            check(miss_tuple == t, {tag, " R3 raw tuple"}, 64'(miss_tuple), 64'(t));
            mtab[mwr] = t;
            mval[mwr] = 1'b1;
            mwr = (mwr == D) ? 1 : mwr + 1;
        end
        check(in_ready == 1'b1, {tag, " R8 ready back"}, 64'(in_ready), 64'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 1; p <= D; p++) mval[p] = 1'b0;
        mwr = 1;
        check(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);
        check(!hit_valid && !miss_valid, "R1 outputs idle", 64'(hit_valid), 64'd0);
    endtask

    task automatic t_fill();
        run_tuple(32'h0403_0201, 0, 1'b0, "R1 first miss");
        run_tuple(32'h1413_1211, 0, 1'b0, "R5 fill pos2");
        run_tuple(32'h2423_2221, 0, 1'b0, "R5 fill pos3");
    endtask

    task automatic t_hits();
        run_tuple(32'h2423_2221, 3, 1'b0, "R4 hit pos3");
        run_tuple(32'h0403_0201, 1, 1'b0, "R4 hit pos1");
        run_tuple(32'h3433_3231, 0, 1'b0, "R5 fill pos4");
        run_tuple(32'h1413_1211, 2, 1'b0, "R6 hit pos2");
    endtask

    task automatic t_wrap();
        // hits above left the insertion position at 1: R6
        run_tuple(32'h4443_4241, 0, 1'b0, "R5 wrap overwrite pos1");
        run_tuple(32'h4443_4241, 1, 1'b0, "R6 new tuple at pos1");
        run_tuple(32'h0403_0201, 0, 1'b0, "R5 oldest evicted");
        run_tuple(32'h3433_3231, 4, 1'b0, "R7 hit last pos");
    endtask

    task automatic t_busy_and_partial();
        run_tuple(32'h0403_0201, 2, 1'b1, "R2 busy input ignored");
        run_tuple(32'h0503_0201, 0, 1'b1, "R4 partial match misses");
        run_tuple(32'h0503_0201, 3, 1'b0, "R2 tuple intact after junk");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_hits();
        t_wrap();
        t_busy_and_partial();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule